// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a single bus master and a target made of 32-bit words. Two address windows are treated as bit aliases, one for RAM and one for peripheral registers, and each window has its own alias base and target base. Every aligned word in an alias window stands for a single bit of one target word. Reading an alias word returns that bit. Writing an alias word sets or clears that bit alone. The bridge does this with a read-modify-write on the downstream port, and no other access can come between the read and the write-back.

Any address outside both windows is sent downstream unchanged, as an ordinary word read or word write. On the upstream side a request is accepted with a valid/ready handshake. Each accepted request gets exactly one single-cycle response pulse, which carries read data and an error flag. The downstream side uses its own valid/ready request handshake. Read data comes back with a separate valid strobe.

Top module: `bitband_bridge`

## Requirements
- R1: For an alias offset `off` (address minus alias base), the target word address is target base + 4 × (`off` >> 7), and the bit index is `off[6:2]`. Bit indices run from 0 to 31.
- R2: An alias read returns the selected target bit in `up_rdata[0]`. Bits 31..1 of `up_rdata` are zero.
- R3: An alias write changes only the selected bit of the target word. All other 31 bits keep their previous values.
- R4: An alias write uses only bit 0 of `up_wdata` as the new bit value. Bits 31..1 have no effect.
- R5: An alias write produces exactly two downstream accesses, one directly after the other: a read of the target word and then a write to the same address. `up_ready` stays low from acceptance until the response, so a request held pending during this time is served only after the write-back.
- R6: The two windows decode independently. The RAM window (alias 0x2200_0000, target 0x2000_0000, 4 KiB of target) and the peripheral window (alias 0x4200_0000, target 0x4000_0000, 4 KiB) each map onto their own target. An address one past the end of a window is not decoded as an alias.
- R7: An address outside both windows is forwarded with the same address, the same direction and the same write data. A read of such an address returns the downstream word unchanged.
- R8: An alias address with nonzero bits [1:0] gets a response with `up_err` = 1 and `up_rdata` = 0, and no downstream access is made. Every other response has `up_err` = 0.
- R9: While `dn_ready` is low, `dn_valid`, `dn_addr`, `dn_write` and `dn_wdata` stay stable. A stalled downstream delays the result but does not change it.
- R10: After reset, `up_ready` = 1, `dn_valid` = 0 and `up_rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_rsp_valid | output | 1 | One-cycle response pulse |
| up_rdata | output | 32 | Response read data |
| up_err | output | 1 | Response error flag (misaligned alias) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
Two functions can overlap in one cycle. A fresh upstream request can be waiting while an alias read-modify-write is still running. The bench provokes this by keeping `up_valid` high with a plain read of the same target word, starting in the cycle right after the alias write is accepted. It then judges three things: that `up_ready` stays low for the whole sequence, that the downstream log shows read, write-back, then the new read in that order, and that the new read returns the already modified word. The same sequence is also run against a downstream that stalls every other cycle.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    K_PASS = 2'd0,
    K_ARD  = 2'd1,
    K_AWR  = 2'd2,
    K_ERR  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_WB    = 2'd3
  } state_e;
endpackage

// File: rtl/bb_alias_window.sv
module bb_alias_window #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter logic [AW-1:0] ALIAS_BASE = '0,
  parameter logic [AW-1:0] TGT_BASE   = '0,
  parameter int unsigned TGT_BYTES  = 4096
) (
  input  logic [AW-1:0]          addr,
  output logic                   hit,
  output logic                   misaligned,
  output logic [AW-1:0]          tgt_addr,
  output logic [$clog2(DW)-1:0]  bit_idx
);
  localparam int unsigned IDXW = $clog2(DW);
  localparam int unsigned SH   = IDXW + 2;
  localparam longint unsigned SPANL = longint'(TGT_BYTES) * longint'(DW);
  localparam logic [AW:0] SPAN = (AW+1)'(SPANL);

  logic [AW-1:0] off;
  logic [AW-1:0] word;

  always_comb begin
    off        = addr - ALIAS_BASE;
    hit        = (addr >= ALIAS_BASE) && ({1'b0, off} < SPAN);
    misaligned = |off[1:0];
    word       = off >> SH;
    tgt_addr   = TGT_BASE + (word << 2);
    bit_idx    = off[SH-1:2];
  end
endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]         word,
  input  logic [$clog2(DW)-1:0] idx,
  input  logic                  new_bit,
  output logic                  sel_bit,
  output logic [DW-1:0]         merged
);
  assign sel_bit = word[idx];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign merged[i] = (idx == i) ? new_bit : word[i];
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int unsigned   AW             = 32,
  parameter int unsigned   DW             = 32,
  parameter logic [AW-1:0] RAM_ALIAS_BASE = 32'h2200_0000,
  parameter logic [AW-1:0] RAM_TGT_BASE   = 32'h2000_0000,
  parameter int unsigned   RAM_TGT_BYTES  = 4096,
  parameter logic [AW-1:0] PER_ALIAS_BASE = 32'h4200_0000,
  parameter logic [AW-1:0] PER_TGT_BASE   = 32'h4000_0000,
  parameter int unsigned   PER_TGT_BYTES  = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          up_rsp_valid,
  output logic [DW-1:0] up_rdata,
  output logic          up_err,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rvalid,
  input  logic [DW-1:0] dn_rdata
);
  import bb_pkg::*;

  localparam int unsigned IDXW = $clog2(DW);
  localparam int unsigned NWIN = 2;
  localparam logic [AW-1:0] ABASE [NWIN] = '{RAM_ALIAS_BASE, PER_ALIAS_BASE};
  localparam logic [AW-1:0] TBASE [NWIN] = '{RAM_TGT_BASE, PER_TGT_BASE};
  localparam int unsigned   TBYTES[NWIN] = '{RAM_TGT_BYTES, PER_TGT_BYTES};

  // Window decoders, one per alias region
  logic [NWIN-1:0] win_hit;
  logic [NWIN-1:0] win_mis;
  logic [AW-1:0]   win_tgt [NWIN];
  logic [IDXW-1:0] win_idx [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    bb_alias_window #(
      .AW(AW), .DW(DW),
      .ALIAS_BASE(ABASE[w]), .TGT_BASE(TBASE[w]), .TGT_BYTES(TBYTES[w])
    ) u_win (
      .addr(up_addr), .hit(win_hit[w]), .misaligned(win_mis[w]),
      .tgt_addr(win_tgt[w]), .bit_idx(win_idx[w])
    );
  end

  // Request classification (lowest-numbered window wins)
  kind_e           kind_d;
  logic [AW-1:0]   addr_d;
  logic [IDXW-1:0] idx_d;

  always_comb begin
    kind_d = K_PASS;
    addr_d = up_addr;
    idx_d  = '0;
    for (int w = NWIN-1; w >= 0; w--) begin
      if (win_hit[w]) begin
        addr_d = win_tgt[w];
        idx_d  = win_idx[w];
        if (win_mis[w])    kind_d = K_ERR;
        else if (up_write) kind_d = K_AWR;
        else               kind_d = K_ARD;
      end
    end
  end

  // Sequencer state
  state_e          state;
  kind_e           kind_q;
  logic [AW-1:0]   addr_q;
  logic [IDXW-1:0] idx_q;
  logic            nbit_q;
  logic [DW-1:0]   data_q;
  logic [DW-1:0]   rd_q;
  logic            we_q;
  logic            rsp_q;
  logic [DW-1:0]   rdata_q;
  logic            err_q;

  logic            sel_bit;
  logic [DW-1:0]   merged;

  bb_bitops #(.DW(DW)) u_bits (
    .word(dn_rdata), .idx(idx_q), .new_bit(nbit_q),
    .sel_bit(sel_bit), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      kind_q  <= K_PASS;
      addr_q  <= '0;
      idx_q   <= '0;
      nbit_q  <= 1'b0;
      data_q  <= '0;
      rd_q    <= '0;
      we_q    <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (up_valid) begin
            kind_q <= kind_d;
            addr_q <= addr_d;
            idx_q  <= idx_d;
            nbit_q <= up_wdata[0];
            data_q <= up_wdata;
            we_q   <= (kind_d == K_PASS) && up_write;
            if (kind_d == K_ERR) begin
              rsp_q   <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else begin
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (dn_ready) begin
            if (we_q) begin
              rsp_q   <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= '0;
              state   <= S_IDLE;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (dn_rvalid) begin
            rd_q <= dn_rdata;
            if (kind_q == K_AWR) begin
              data_q <= merged;
              we_q   <= 1'b1;
              state  <= S_WB;
            end else begin
              rsp_q   <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= (kind_q == K_ARD) ? DW'(sel_bit) : dn_rdata;
              state   <= S_IDLE;
            end
          end
        end
        S_WB: begin
          if (dn_ready) begin
            rsp_q   <= 1'b1;
            err_q   <= 1'b0;
            rdata_q <= '0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign up_ready     = (state == S_IDLE);
  assign up_rsp_valid = rsp_q;
  assign up_rdata     = rdata_q;
  assign up_err       = err_q;
  assign dn_valid     = (state == S_ISSUE) || (state == S_WB);
  assign dn_write     = we_q;
  assign dn_addr      = addr_q;
  assign dn_wdata     = data_q;

  // Checks next to the sequencer
  assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (up_rsp_valid && kind_q == K_ARD) |-> (up_rdata[DW-1:1] == '0));

  assert_one_bit_change_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB) |-> ($countones(dn_wdata ^ rd_q) <= 1));

  assert_wb_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB && $past(state) == S_WAIT) |-> (dn_addr == $past(dn_addr) && dn_write));

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> !up_ready);

  assert_err_no_access_R8: assert property (@(posedge clk) disable iff (rst)
    (up_rsp_valid && up_err) |-> (!$past(dn_valid) && up_rdata == '0));

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RAM_A = 32'h2200_0000;
  localparam logic [31:0] RAM_T = 32'h2000_0000;
  localparam logic [31:0] PER_A = 32'h4200_0000;
  localparam logic [31:0] PER_T = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic up_ready, up_rsp_valid, up_err;
  logic [31:0] up_rdata;
  logic dn_valid, dn_write;
  logic [31:0] dn_addr, dn_wdata;
  logic dn_ready, dn_rvalid;
  logic [31:0] dn_rdata;
  logic stall = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge dut (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata), .up_err(up_err),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  // Downstream target model with access log
  logic [31:0] mem [64];
  int          dn_cnt;
  logic        log_we   [16];
  logic [31:0] log_addr [16];

  function automatic int midx(input logic [31:0] a);
    return {25'd0, a[30], a[6:2]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h1357_9BDF ^ (i * 32'h0101_0101);
      dn_ready  <= 1'b1;
      dn_rvalid <= 1'b0;
      dn_rdata  <= '0;
      dn_cnt    <= 0;
    end else begin
      dn_ready  <= stall ? ~dn_ready : 1'b1;
      dn_rvalid <= 1'b0;
      if (dn_valid && dn_ready) begin
        log_we[dn_cnt % 16]   <= dn_write;
        log_addr[dn_cnt % 16] <= dn_addr;
        dn_cnt <= dn_cnt + 1;
        if (dn_write) mem[midx(dn_addr)] <= dn_wdata;
        else begin
          dn_rvalid <= 1'b1;
          dn_rdata  <= mem[midx(dn_addr)];
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] alias_of(input logic [31:0] abase, input int word, input int b);
    return abase + word * 128 + b * 4;
  endfunction

  task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    up_valid = 1'b1; up_write = we; up_addr = a; up_wdata = d;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    rd = up_rdata;
    er = up_err;
  endtask

  task automatic t_reset();
    chk("R10 up_ready", {31'd0, up_ready}, 32'd1);
    chk("R10 dn_valid", {31'd0, dn_valid}, 32'd0);
    chk("R10 rsp_valid", {31'd0, up_rsp_valid}, 32'd0);
  endtask

  task automatic t_pass();
    logic [31:0] rd; logic er; int c0;
    c0 = dn_cnt;
    xfer(1'b1, RAM_T + 32'h8, 32'hDEAD_BEEF, rd, er);
    chk("R7 write reaches target", mem[midx(RAM_T + 32'h8)], 32'hDEAD_BEEF);
    chk("R7 write addr", log_addr[c0 % 16], RAM_T + 32'h8);
    chk("R8 pass err", {31'd0, er}, 32'd0);
    xfer(1'b0, PER_T + 32'h10, 32'h0, rd, er);
    chk("R7 read data", rd, mem[midx(PER_T + 32'h10)]);
  endtask

  task automatic t_alias_read(input logic [31:0] ab, input logic [31:0] tb, input int w, input int b);
    logic [31:0] rd; logic er; logic [31:0] tgt; int c0;
    tgt = tb + w * 4;
    c0 = dn_cnt;
    xfer(1'b0, alias_of(ab, w, b), 32'hFFFF_FFFF, rd, er);
    chk("R2 alias read bit", rd, (mem[midx(tgt)] >> b) & 32'd1);
    chk("R1 R6 alias target addr", log_addr[c0 % 16], tgt);
  endtask

  task automatic t_alias_write(input logic [31:0] ab, input logic [31:0] tb, input int w, input int b,
                               input logic [31:0] d);
    logic [31:0] rd; logic er; logic [31:0] tgt, old, exp; int c0;
    tgt = tb + w * 4;
    old = mem[midx(tgt)];
    exp = (old & ~(32'd1 << b)) | ({31'd0, d[0]} << b);
    c0 = dn_cnt;
    xfer(1'b1, alias_of(ab, w, b), d, rd, er);
    @(negedge clk);
    chk("R3 R4 alias write result", mem[midx(tgt)], exp);
    chk("R5 two accesses", dn_cnt - c0, 32'd2);
    chk("R5 read then write", {30'd0, log_we[c0 % 16], log_we[(c0+1) % 16]}, 32'd1);
    chk("R5 same address", log_addr[(c0+1) % 16], tgt);
  endtask

  task automatic t_misaligned();
    logic [31:0] rd; logic er; int c0; logic [31:0] old;
    old = mem[midx(RAM_T)];
    c0 = dn_cnt;
    xfer(1'b1, RAM_A + 32'h1, 32'h0, rd, er);
    chk("R8 err on misaligned write", {31'd0, er}, 32'd1);
    @(negedge clk);
    chk("R8 no downstream access", dn_cnt - c0, 32'd0);
    chk("R8 target untouched", mem[midx(RAM_T)], old);
    xfer(1'b0, PER_A + 32'h2, 32'h0, rd, er);
    chk("R8 err on misaligned read", {31'd0, er}, 32'd1);
    chk("R8 rdata zero", rd, 32'd0);
  endtask

  task automatic t_edges();
    logic [31:0] rd; logic er; int c0;
    t_alias_read(RAM_A, RAM_T, 1023, 31);
    c0 = dn_cnt;
    xfer(1'b0, RAM_A + 32'h0002_0000, 32'h0, rd, er);
    chk("R6 past window is pass-through", log_addr[c0 % 16], RAM_A + 32'h0002_0000);
    chk("R7 past window data", rd, mem[midx(RAM_A + 32'h0002_0000)]);
  endtask

  task automatic t_overlap();
    logic [31:0] tgt, exp; int c0; int busy;
    tgt = RAM_T + 32'd6 * 4;
    exp = mem[midx(tgt)] ^ (32'd1 << 12);
    c0 = dn_cnt;
    @(negedge clk);
    up_valid = 1'b1; up_write = 1'b1; up_addr = alias_of(RAM_A, 6, 12);
    up_wdata = {31'd0, ~mem[midx(tgt)][12]};
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_write = 1'b0; up_addr = tgt; up_wdata = '0;
    busy = 0;
    while (!up_rsp_valid) begin
      if (!up_ready) busy++;
      @(negedge clk);
    end
    @(negedge clk);
    up_valid = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    chk("R5 held request sees new word", up_rdata, exp);
    chk("R5 ready low during RMW", {31'd0, busy >= 3}, 32'd1);
    chk("R5 order R W R", {29'd0, log_we[c0 % 16], log_we[(c0+1) % 16], log_we[(c0+2) % 16]}, 32'b010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pass();
    t_alias_read(RAM_A, RAM_T, 3, 0);
    t_alias_read(RAM_A, RAM_T, 3, 31);
    t_alias_read(PER_A, PER_T, 5, 17);
    t_alias_write(RAM_A, RAM_T, 2, 7, 32'h0000_0001);
    t_alias_write(RAM_A, RAM_T, 2, 7, 32'hFFFF_FFFE);
    t_alias_write(PER_A, PER_T, 9, 0, 32'h0000_0001);
    t_alias_write(PER_A, PER_T, 9, 31, 32'h0000_0000);
    t_misaligned();
    t_edges();
    t_overlap();
    stall = 1'b1;
    t_alias_write(RAM_A, RAM_T, 4, 3, 32'h0000_0001);  // R9 under stall
    t_alias_read(PER_A, PER_T, 4, 3);                   // R9 under stall
    t_overlap();
    stall = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule